// File: doc/BRIEF.md
# Dual-Clock 8-bit Timer with Synchronized Host Access

An 8-bit up-counter that takes its clock from either the host I/O clock or a free-running external oscillator input. A 10-bit prescaler sits in front of the counter. A 3-bit divide field picks one of the prescaler taps, and a one-shot request clears the prescaler. The host bus always runs on the I/O clock. Every value that crosses between the two domains goes through a synchronizer.

The host sees the count through a holding copy that the timer refreshes on each of its clock edges. Writes to the compare and divide registers are carried into the timer domain by a toggle handshake. A busy flag stays up for each register until its transfer completes. Overflow and compare-match events reach the host as sticky flags, arriving some cycles after the event. The compare output pin toggles directly in the timer domain.

Sleep is modelled only by stopping the I/O clock. The counter keeps running on the oscillator while the host copy stays frozen.

Top module: `async_timer`

## Requirements
- R1: After reset the count copy reads 0, the status register (address 4) reads 0, and both `irq` and `cmp_out` are 0.
- R2: Address 3 bit 0 selects the counter clock: 0 uses `clk_io`, 1 uses `osc_in`. With 1 selected and no oscillator edges, the count does not move. With 0 selected and divide 1, the count rises by exactly one per I/O cycle.
- R3: The control register (address 2) bits [2:0] select the divide ratio: 0 stops the counter, and 1..7 divide by 1, 8, 32, 64, 128, 256 and 1024. Over N×k timer edges at ratio N, the count rises by exactly k.
- R4: Writing 1 to control bit 3 clears the prescaler on the timer edge that takes the transfer. At divide 8, the first count step after that edge comes on the eighth following timer edge.
- R5: Address 0 returns the count as it stood after the latest timer edge, once 4 I/O cycles have passed since that edge (for a timer clock at least 4 times slower than `clk_io`).
- R6: If `clk_io` stops while the timer keeps running, the first read after the restart returns the value held before the stop. The copy only catches up after the synchronizer latency.
- R7: A write to the compare register (address 1) or the control register sets its busy flag (status bit 2 or bit 3). The flag clears only once the timer domain has taken the value. Writes to a register whose busy flag is set are ignored, and its readback stays unchanged.
- R8: When the counter wraps from 255 to 0, status bit 0 (overflow) is set.
- R9: A compare match, meaning the counter steps onto the compare value, sets status bit 1. The flag appears one timer edge plus 3 I/O cycles after the match, so the count the host sees has moved on by at least one.
- R10: `cmp_out` toggles on the timer edge where the counter steps onto the compare value. It is not resynchronized to `clk_io`.
- R11: Writing 1 to a status flag bit clears only that flag. A flag set in the same cycle as its clear stays set.
- R12: `irq` is high one I/O cycle after either status flag is set, and low one cycle after both are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | Host I/O clock; may be stopped to model sleep |
| osc_in | input | 1 | External oscillator, counter clock when selected |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address (0 count, 1 compare, 2 control, 3 clock select, 4 status) |
| bus_wr | input | 1 | Write strobe, one I/O cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, one cycle after the address |
| irq | output | 1 | Any status flag set |
| cmp_out | output | 1 | Compare output, driven in the timer domain |

## Verification
Corrupted prescaler or counter state shows up as a count delta at the read port. The bench measures that delta over a whole number of divide periods, so any drift appears after the first window of N×k oscillator edges. A broken handshake shows up either as a busy flag that never drops or as a compare readback that changes under a write that should have been ignored. Both are visible on the next status or compare read. A lost or mistimed event toggle appears as a status flag missing one timer edge after the counter reaches the compare or wrap value, or present one edge too early.

// File: rtl/atim_pkg.sv
`timescale 1ns/1ps
package atim_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_SRC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  // Number of low prescaler bits that must all be ones for a tick.
  function automatic int tap_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/atim_sync.sv
`timescale 1ns/1ps
module atim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain <= rst ? 1'b0 : d;
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/atim_wr_xfer.sv
`timescale 1ns/1ps
module atim_wr_xfer #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_h,
  input  logic         clk_t,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] host_q,
  output logic         busy,
  output logic [W-1:0] t_q,
  output logic         t_load
);
  logic req_tog, ack_tog, req_s, ack_s;

  // host side: value held stable while the request is outstanding
  always_ff @(posedge clk_h) begin
    if (rst) begin
      host_q  <= '0;
      req_tog <= 1'b0;
    end else if (wr && !busy) begin
      host_q  <= wdata;
      req_tog <= ~req_tog;
    end
  end

  atim_sync #(.STAGES(STAGES)) u_req (.clk(clk_t), .rst(rst), .d(req_tog), .q(req_s));
  atim_sync #(.STAGES(STAGES)) u_ack (.clk(clk_h), .rst(rst), .d(ack_tog), .q(ack_s));

  assign busy   = req_tog ^ ack_s;
  assign t_load = req_s ^ ack_tog;

  always_ff @(posedge clk_t) begin
    if (rst) begin
      ack_tog <= 1'b0;
      t_q     <= '0;
    end else if (t_load) begin
      ack_tog <= req_s;
      t_q     <= host_q;
    end
  end
endmodule

// File: rtl/atim_prescaler.sv
`timescale 1ns/1ps
module atim_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [2:0] cs,
  output logic       tick
);
  logic [PRE_W-1:0] pre, mask;

  function automatic logic [PRE_W-1:0] tap_mask(input logic [2:0] sel);
    logic [PRE_W:0] one_sh;
    one_sh = (PRE_W+1)'(1) << atim_pkg::tap_shift(sel);
    return PRE_W'(one_sh - 1'b1);
  endfunction

  assign mask = tap_mask(cs);
  assign tick = (cs != 3'd0) && ((pre & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) pre <= '0;
    else            pre <= pre + 1'b1;
  end
endmodule

// File: rtl/atim_count.sv
`timescale 1ns/1ps
module atim_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap,
  output logic             snap_tog,
  output logic             ovf_tog,
  output logic             cmp_tog,
  output logic             cmp_out
);
  logic [CNT_W-1:0] cnt_nx;
  logic             hit, wrap, hit_p, wrap_p;

  assign cnt_nx = cnt + CNT_W'(tick);
  assign hit    = tick && (cnt_nx == cmp);
  assign wrap   = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      snap     <= '0;
      snap_tog <= 1'b0;
      hit_p    <= 1'b0;
      wrap_p   <= 1'b0;
      ovf_tog  <= 1'b0;
      cmp_tog  <= 1'b0;
      cmp_out  <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      snap     <= cnt_nx;
      snap_tog <= ~snap_tog;
      cmp_out  <= cmp_out ^ hit;
      hit_p    <= hit;
      wrap_p   <= wrap;
      cmp_tog  <= cmp_tog ^ hit_p;
      ovf_tog  <= ovf_tog ^ wrap_p;
    end
  end
endmodule

// File: rtl/async_timer.sv
`timescale 1ns/1ps
module async_timer #(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_io,
  input  logic                        osc_in,
  input  logic                        rst,
  input  logic [atim_pkg::ADDR_W-1:0] bus_addr,
  input  logic                        bus_wr,
  input  logic [CNT_W-1:0]            bus_wdata,
  output logic [CNT_W-1:0]            bus_rdata,
  output logic                        irq,
  output logic                        cmp_out
);
  import atim_pkg::*;
  localparam int CS_W  = 3;
  localparam int N_EVT = 3;  // 0 snapshot, 1 overflow, 2 compare

  logic             src_sel, tclk;
  logic             cmp_busy, ctrl_busy, cmp_load, ctrl_load, clr_req;
  logic [CNT_W-1:0] cmp_host, cmp_t, cnt, snap, hold;
  logic [CS_W-1:0]  cs_host, cs_t;
  logic             tick, pre_clr;
  logic [N_EVT-1:0] evt_tog, evt_s, evt_seen, evt_pulse;
  logic             ovf_set, cmp_set, ovf_flag, cmp_flag;
  logic             wr_cmp, wr_ctrl, wr_stat;

  assign tclk    = src_sel ? osc_in : clk_io;
  assign wr_cmp  = bus_wr && (bus_addr == A_CMP);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);

  atim_wr_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cmp_x (
    .clk_h(clk_io), .clk_t(tclk), .rst(rst), .wr(wr_cmp), .wdata(bus_wdata),
    .host_q(cmp_host), .busy(cmp_busy), .t_q(cmp_t), .t_load(cmp_load));

  atim_wr_xfer #(.W(CS_W), .STAGES(SYNC_STAGES)) u_ctrl_x (
    .clk_h(clk_io), .clk_t(tclk), .rst(rst), .wr(wr_ctrl), .wdata(bus_wdata[CS_W-1:0]),
    .host_q(cs_host), .busy(ctrl_busy), .t_q(cs_t), .t_load(ctrl_load));

  assign pre_clr = ctrl_load && clr_req;

  atim_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(tclk), .rst(rst), .clr(pre_clr), .cs(cs_t), .tick(tick));

  atim_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(tclk), .rst(rst), .tick(tick), .cmp(cmp_t), .cnt(cnt), .snap(snap),
    .snap_tog(evt_tog[0]), .ovf_tog(evt_tog[1]), .cmp_tog(evt_tog[2]), .cmp_out(cmp_out));

  generate
    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
      atim_sync #(.STAGES(SYNC_STAGES)) u_s (.clk(clk_io), .rst(rst), .d(evt_tog[i]), .q(evt_s[i]));
    end
  endgenerate

  assign evt_pulse = evt_s ^ evt_seen;
  assign ovf_set   = evt_pulse[1];
  assign cmp_set   = evt_pulse[2];

  always_ff @(posedge clk_io) begin
    if (rst) begin
      src_sel   <= 1'b0;
      clr_req   <= 1'b0;
      evt_seen  <= '0;
      hold      <= '0;
      ovf_flag  <= 1'b0;
      cmp_flag  <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && (bus_addr == A_SRC)) src_sel <= bus_wdata[0];
      if (wr_ctrl && !ctrl_busy)         clr_req <= bus_wdata[CS_W];
      evt_seen <= evt_s;
      if (evt_pulse[0]) hold <= snap;
      ovf_flag <= (ovf_flag && !(wr_stat && bus_wdata[0])) || ovf_set;
      cmp_flag <= (cmp_flag && !(wr_stat && bus_wdata[1])) || cmp_set;
      irq      <= ovf_flag || cmp_flag;
      case (bus_addr)
        A_CNT:   bus_rdata <= hold;
        A_CMP:   bus_rdata <= cmp_host;
        A_CTRL:  bus_rdata <= CNT_W'(cs_host);
        A_SRC:   bus_rdata <= CNT_W'(src_sel);
        A_STAT:  bus_rdata <= CNT_W'({ctrl_busy, cmp_busy, cmp_flag, ovf_flag});
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/atim_chk.sv
`timescale 1ns/1ps
module atim_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_io,
  input logic             tclk,
  input logic             rst,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic             cmp_busy,
  input logic [CNT_W-1:0] cmp_host,
  input logic             ovf_set,
  input logic             cmp_set,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic             irq,
  input logic [2:0]       cs_t,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_t,
  input logic             cmp_out
);
  assert_stopped_hold_R3: assert property (@(posedge tclk) disable iff (rst)
    (cs_t == 3'd0) |=> $stable(cnt));

  assert_single_step_R3: assert property (@(posedge tclk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_pin_on_match_R10: assert property (@(posedge tclk) disable iff (rst)
    (!$stable(cmp_out) && $stable(cmp_t)) |-> (cnt == cmp_t));

  assert_busy_write_ignored_R7: assert property (@(posedge clk_io) disable iff (rst)
    (bus_wr && bus_addr == atim_pkg::A_CMP && cmp_busy) |=> $stable(cmp_host));

  assert_ovf_set_wins_R11: assert property (@(posedge clk_io) disable iff (rst)
    ovf_set |=> ovf_flag);

  assert_cmp_set_wins_R11: assert property (@(posedge clk_io) disable iff (rst)
    cmp_set |=> cmp_flag);

  assert_irq_follows_R12: assert property (@(posedge clk_io) disable iff (rst)
    1'b1 |=> (irq == $past(ovf_flag || cmp_flag)));
endmodule

bind async_timer atim_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_io(clk_io), .tclk(tclk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cmp_busy(cmp_busy), .cmp_host(cmp_host), .ovf_set(ovf_set), .cmp_set(cmp_set),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq(irq), .cs_t(cs_t), .cnt(cnt),
  .cmp_t(cmp_t), .cmp_out(cmp_out));

// File: tb/sim_async_timer.sv
`timescale 1ns/1ps
module sim_async_timer;
  logic       clk_io = 1'b0, osc_in = 1'b0, rst = 1'b1, io_run = 1'b1;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, cmp_out;
  int         tests = 0, fails = 0;
  bit         done = 1'b0;

  async_timer u0 (.clk_io(clk_io), .osc_in(osc_in), .rst(rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cmp_out(cmp_out));

  initial forever begin
    #5;
    if (io_run) clk_io = ~clk_io;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_io); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk_io); bus_wr = 1'b0; bus_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk_io); bus_addr = a;
    @(negedge clk_io); v = bus_rdata; bus_addr = 3'd0;
  endtask

  task automatic osc_edge();
    osc_in = 1'b1; #50; osc_in = 1'b0; #50;
  endtask

  task automatic idle_sync();
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(3'd4, s);
      if (s[3:2] == 2'b00) break;
    end
  endtask

  task automatic idle_async();
    logic [7:0] s;
    for (int i = 0; i < 20; i++) begin
      rd(3'd4, s);
      if (s[3:2] == 2'b00) break;
      osc_edge();
    end
  endtask

  function automatic int ratio(input int cs);
    case (cs)
      1: return 1;    2: return 8;   3: return 32;  4: return 64;
      5: return 128;  6: return 256; default: return 1024;
    endcase
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, c0, c1, tgt;
    logic       p0;
    repeat (6) @(posedge clk_io);
    @(negedge clk_io); rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); check("R1 count", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
    check("R1 cmp_out", cmp_out, 0);

    // R7 busy in I/O-clock mode
    wr(3'd2, 8'd1);
    rd(3'd4, v); check("R7 ctrl busy set", v[3], 1);
    idle_sync();
    rd(3'd4, v); check("R7 ctrl busy cleared", v[3], 0);

    // R2 I/O clock source, divide 1: one per cycle
    rd(3'd0, c0);
    repeat (48) @(negedge clk_io);
    rd(3'd0, c1);
    check("R2 io-clock delta", 8'(c1 - c0), 50);

    // R3 divide 8 in I/O mode
    wr(3'd2, 8'd2); idle_sync();
    rd(3'd0, c0);
    repeat (398) @(negedge clk_io);
    rd(3'd0, c1);
    check("R3 div8 io delta", 8'(c1 - c0), 50);

    // switch to oscillator
    wr(3'd3, 8'd1);
    wr(3'd2, 8'd1); idle_async();
    rd(3'd0, c0);
    repeat (100) @(negedge clk_io);
    rd(3'd0, c1);
    check("R2 no osc edges no count", c1, c0);

    // R7 write while busy ignored
    wr(3'd1, 8'h40);
    rd(3'd4, v); check("R7 cmp busy set", v[2], 1);
    wr(3'd1, 8'h41);
    rd(3'd1, v); check("R7 ignored write", v, 8'h40);
    idle_async();
    rd(3'd4, v); check("R7 cmp busy cleared", v[2], 0);
    rd(3'd1, v); check("R7 cmp readback", v, 8'h40);

    // R3 sweep of all ratios
    for (int cs = 1; cs < 8; cs++) begin
      int k;
      k = (cs == 7) ? 1 : 2;
      wr(3'd2, 8'(cs)); idle_async();
      rd(3'd0, c0);
      repeat (ratio(cs) * k) osc_edge();
      rd(3'd0, c1);
      check($sformatf("R3 ratio sel %0d", cs), 8'(c1 - c0), k);
    end

    // R3 stop
    wr(3'd2, 8'd0); idle_async();
    rd(3'd0, c0);
    repeat (10) osc_edge();
    rd(3'd0, c1);
    check("R3 stopped", c1, c0);

    // R4 prescaler clear with divide 8
    wr(3'd2, 8'h0A); idle_async();
    rd(3'd0, c0);
    repeat (7) osc_edge();
    rd(3'd0, c1); check("R4 no step in 7 edges", c1, c0);
    osc_edge();
    rd(3'd0, c1); check("R4 step on 8th edge", c1, 8'(c0 + 1));

    // R5 fresh copy after each edge
    wr(3'd2, 8'd1); idle_async();
    rd(3'd0, c0);
    osc_edge(); rd(3'd0, c1); check("R5 copy +1", c1, 8'(c0 + 1));
    osc_edge(); rd(3'd0, c1); check("R5 copy +2", c1, 8'(c0 + 2));

    // R6 stale copy after I/O clock stop
    rd(3'd0, c0);
    @(negedge clk_io); #1 io_run = 1'b0;
    repeat (3) osc_edge();
    io_run = 1'b1;
    @(negedge clk_io); check("R6 first read stale", bus_rdata, c0);
    repeat (6) @(negedge clk_io);
    rd(3'd0, c1); check("R6 caught up", c1, 8'(c0 + 3));

    // R9 / R10 compare
    rd(3'd0, c0);
    tgt = 8'(c0 + 12);
    wr(3'd1, tgt); idle_async();
    osc_edge(); osc_edge();
    wr(3'd4, 8'h03);
    p0 = cmp_out;
    rd(3'd0, v);
    for (int i = 0; i < 30 && v != tgt; i++) begin
      osc_edge(); rd(3'd0, v);
    end
    check("R9 reached compare", v, tgt);
    check("R10 pin toggled", cmp_out, !p0);
    rd(3'd4, v); check("R9 flag not yet", v[1], 0);
    osc_edge();
    rd(3'd0, v); check("R9 counter advanced", v, 8'(tgt + 1));
    rd(3'd4, v); check("R9 flag set", v[1], 1);
    check("R12 irq high", irq, 1);

    // R8 overflow
    wr(3'd4, 8'h01);
    rd(3'd0, v);
    for (int i = 0; i < 300 && v != 8'hFF; i++) begin
      osc_edge(); rd(3'd0, v);
    end
    rd(3'd4, v); check("R8 no ovf before wrap", v[0], 0);
    osc_edge();
    rd(3'd0, v); check("R8 wrapped", v, 0);
    osc_edge();
    rd(3'd4, v); check("R8 ovf set", v[0], 1);

    // R11 selective clear, R12 irq low
    wr(3'd4, 8'h01);
    rd(3'd4, v); check("R11 clear ovf only", v[1:0], 2);
    wr(3'd4, 8'h02);
    rd(3'd4, v); check("R11 clear cmp", v[1:0], 0);
    repeat (2) @(negedge clk_io);
    check("R12 irq low", irq, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule